// File: doc/BRIEF.md
# Burst Address Counter Register

This block holds the address of one memory port. On every rising clock edge it picks its next value from a fixed priority among three active-low controls:
- a clear control forces the address to zero;
- a strobe captures the address presented on the external bus;
- a count control moves the address to the following location;
- with none of them asserted, the address stays where it is.

The register output is the address the port uses for the access of that cycle. A load, an advance or a clear therefore takes effect for the access that follows the same edge.

The controls act on every edge, whatever the selection state of the port. A burst can therefore keep advancing while the port is idle. The address width is a parameter: 16 bits by default, and 15 bits as the narrower setting. An increment past the all-ones address wraps to zero.

Top module: `burst_addr_reg`

## Requirements
- R1: While the synchronous active-high `rst` is high at a rising edge, `int_addr` becomes 0 after that edge, whatever the other inputs are.
- R2: With `rst` low and `cnt_clr_n` low at a rising edge, `int_addr` becomes 0, whatever `ext_addr`, `adr_stb_n` and `cnt_step_n` are.
- R3: With `cnt_clr_n` high and `adr_stb_n` low at a rising edge, `int_addr` takes the value of `ext_addr`, whether `cnt_step_n` is high or low.
- R4: With `cnt_clr_n` high, `adr_stb_n` high and `cnt_step_n` low at a rising edge, `int_addr` becomes its previous value plus one.
- R5: An advance from the all-ones address gives 0.
- R6: With `cnt_clr_n`, `adr_stb_n` and `cnt_step_n` all high at a rising edge, `int_addr` keeps its value and `ext_addr` has no effect.
- R7: With `ADDR_W` = 15, the register keeps 15 bits: a load of 0x7FFF followed by an advance gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | ADDR_W | External address bus |
| adr_stb_n | input | 1 | Address strobe, active low: load `ext_addr` |
| cnt_step_n | input | 1 | Count control, active low: advance by one |
| cnt_clr_n | input | 1 | Counter clear, active low: force zero |
| int_addr | output | ADDR_W | Registered internal address for the current access |

## Verification
The bench targets the priority collisions, because a wrong priority shows up as a wrong address only when two controls are asserted together:
- clear asserted together with a strobe: a design that lets the strobe win loads the bus value instead of zero;
- strobe asserted together with the count control: a design that lets counting win returns the old address plus one instead of the bus value.

It also drives an advance from all-ones at both widths. A design that is too wide yields 0x8000 in place of zero, and one that saturates sticks at all-ones.

During hold cycles the external bus changes. A register that samples the bus in the wrong mode leaks those values onto the output.

// File: rtl/bac_pkg.sv
package bac_pkg;

  // Next-address selection, resolved from the three active-low controls
  typedef enum logic [1:0] {
    SEL_KEEP = 2'd0,
    SEL_STEP = 2'd1,
    SEL_LOAD = 2'd2,
    SEL_ZERO = 2'd3
  } addr_sel_e;

endpackage

// File: rtl/bac_decode.sv
module bac_decode
  import bac_pkg::*;
(
  input  logic      adr_stb_n,
  input  logic      cnt_step_n,
  input  logic      cnt_clr_n,
  output addr_sel_e sel
);

  // Fixed priority: clear, then load, then step, then keep
  always_comb begin
    if (!cnt_clr_n)       sel = SEL_ZERO;
    else if (!adr_stb_n)  sel = SEL_LOAD;
    else if (!cnt_step_n) sel = SEL_STEP;
    else                  sel = SEL_KEEP;
  end

endmodule

// File: rtl/bac_next.sv
module bac_next
  import bac_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  addr_sel_e         sel,
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] ext,
  output logic [ADDR_W-1:0] nxt
);

  localparam logic [ADDR_W-1:0] ONE  = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] ZERO = '0;

  logic [ADDR_W-1:0] stepped;

  // Modulo-2^ADDR_W increment: the carry out is dropped, so all-ones wraps to zero
  assign stepped = cur + ONE;

  always_comb begin
    unique case (sel)
      SEL_ZERO: nxt = ZERO;
      SEL_LOAD: nxt = ext;
      SEL_STEP: nxt = stepped;
      default:  nxt = cur;
    endcase
  end

endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg
  import bac_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              adr_stb_n,
  input  logic              cnt_step_n,
  input  logic              cnt_clr_n,
  output logic [ADDR_W-1:0] int_addr
);

  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  addr_sel_e         sel;
  logic [ADDR_W-1:0] nxt;
  logic [ADDR_W-1:0] addr_q;
  logic              hist_ok;

  bac_decode u_dec (
    .adr_stb_n (adr_stb_n),
    .cnt_step_n(cnt_step_n),
    .cnt_clr_n (cnt_clr_n),
    .sel       (sel)
  );

  bac_next #(.ADDR_W(ADDR_W)) u_nxt (
    .sel(sel),
    .cur(addr_q),
    .ext(ext_addr),
    .nxt(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      hist_ok <= 1'b0;
    end else begin
      addr_q  <= nxt;
      hist_ok <= 1'b1;
    end
  end

  assign int_addr = addr_q;

  // R2
  clr_wins_chk: assert property (@(posedge clk) disable iff (rst || !hist_ok)
    !$past(cnt_clr_n) |-> int_addr == '0);

  // R3
  load_ext_chk: assert property (@(posedge clk) disable iff (rst || !hist_ok)
    ($past(cnt_clr_n) && !$past(adr_stb_n)) |-> int_addr == $past(ext_addr));

  // R4
  step_one_chk: assert property (@(posedge clk) disable iff (rst || !hist_ok)
    ($past(cnt_clr_n) && $past(adr_stb_n) && !$past(cnt_step_n))
      |-> int_addr == ADDR_W'($past(int_addr) + ONE));

  // R6
  keep_addr_chk: assert property (@(posedge clk) disable iff (rst || !hist_ok)
    ($past(cnt_clr_n) && $past(adr_stb_n) && $past(cnt_step_n)) |-> $stable(int_addr));

endmodule

// File: tb/sim_burst_addr_reg.sv
module sim_burst_addr_reg;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ext = '0;
  logic        stb_n = 1'b1;
  logic        step_n = 1'b1;
  logic        clr_n = 1'b1;
  logic [15:0] out16;
  logic [14:0] out15;

  logic [15:0] exp16 = '0;
  logic [14:0] exp15 = '0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  burst_addr_reg #(.ADDR_W(16)) u0 (
    .clk(clk), .rst(rst), .ext_addr(ext), .adr_stb_n(stb_n),
    .cnt_step_n(step_n), .cnt_clr_n(clr_n), .int_addr(out16)
  );

  burst_addr_reg #(.ADDR_W(15)) u1 (
    .clk(clk), .rst(rst), .ext_addr(ext[14:0]), .adr_stb_n(stb_n),
    .cnt_step_n(step_n), .cnt_clr_n(clr_n), .int_addr(out15)
  );

  // Reference model from the requirements; mask selects the width
  function automatic logic [15:0] ref_next(logic [15:0] cur, logic [15:0] e,
                                           logic r, logic s, logic st, logic c,
                                           logic [15:0] mask);
    if (r)        return 16'h0;
    else if (!c)  return 16'h0;
    else if (!s)  return e & mask;
    else if (!st) return (cur + 16'h1) & mask;
    else          return cur;
  endfunction

  function automatic string req_of(logic r, logic s, logic st, logic c);
    if (r)        return "R1";
    else if (!c)  return "R2";
    else if (!s)  return "R3";
    else if (!st) return "R4";
    else          return "R6";
  endfunction

  // Drive on the falling edge, let one rising edge pass, compare on the next falling edge
  task automatic apply(logic r, logic [15:0] e, logic s, logic st, logic c, string tag);
    string t;
    rst = r; ext = e; stb_n = s; step_n = st; clr_n = c;
    exp16 = ref_next(exp16, e, r, s, st, c, 16'hFFFF);
    exp15 = 15'(ref_next({1'b0, exp15}, e, r, s, st, c, 16'h7FFF));
    t = (tag == "") ? req_of(r, s, st, c) : tag;
    @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (out16 !== exp16) begin
      n_bad++;
      $display("FAIL %s w16: got %h expected %h", t, out16, exp16);
    end
    if (out15 !== exp15) begin
      n_bad++;
      $display("FAIL %s w15: got %h expected %h", t, out15, exp15);
    end
  endtask

  initial begin
    process::self().srandom(32'd1234);
    @(negedge clk);
    apply(1, 16'hBEEF, 0, 0, 1, "R1");            // reset state, strobe ignored
    apply(0, 16'h1234, 0, 1, 1, "R3");            // plain load
    apply(0, 16'h5678, 0, 0, 1, "R3");            // load beats step
    apply(0, 16'hAAAA, 1, 0, 1, "R4");            // step
    apply(0, 16'h0F0F, 1, 1, 1, "R6");            // keep, bus ignored
    apply(0, 16'hFFFF, 1, 1, 1, "R6");
    apply(0, 16'h9999, 0, 0, 0, "R2");            // clear beats load and step
    apply(0, 16'hFFFF, 0, 1, 1, "R3");            // all-ones load
    apply(0, 16'h0000, 1, 0, 1, "R5");            // wrap to zero (both widths)
    apply(0, 16'h7FFF, 0, 1, 1, "R7");            // 15-bit all-ones
    apply(0, 16'h0000, 1, 0, 1, "R7");            // w15 wraps, w16 gives 8000
    apply(0, 16'h4321, 0, 1, 1, "R3");
    apply(1, 16'h4321, 1, 0, 1, "R1");            // reset mid-run
    apply(0, 16'h0000, 1, 0, 1, "R4");
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] e;
      e = 16'($urandom);
      if ($urandom_range(0, 7) == 0) e = 16'hFFFF;
      apply($urandom_range(0, 63) == 0, e,
            $urandom_range(0, 3) == 0,
            $urandom_range(0, 2) != 0,
            $urandom_range(0, 9) != 0, "");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule